// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Controller

This block is the ordering point for coherence on a small set of memory blocks shared by several caches. For each block it keeps one presence bit per cache and one exclusive bit. Caches send it read or write (ownership) requests. Before granting a request that conflicts with copies held elsewhere, the directory sends invalidations to those holders and waits until every one of them has acknowledged. It then grants the block to the requester and rewrites that block's entry. Data transfer, the network and cache internals are outside this block.

Requests arrive on a valid/ready channel. A requester raises `req_valid` with the cache id, block index and kind, and must hold all of them stable until a cycle in which `req_ready` is also high. That cycle is the acceptance. The directory runs one transaction at a time. While a transaction waits for acknowledgements, `req_ready` stays low, so every later request, including any to the same block, is held back. Invalidations are a level per cache, `inv_req[i]`, qualified by `inv_blk`. A cache answers with a one-cycle pulse on `inv_ack[i]`. The grant is a one-cycle pulse with no back-pressure.

Top module: `bitvec_dir`

## Requirements
- R1: After reset, every block has no holders and a clear exclusive bit, `req_ready` is 1, `inv_req` is 0 and `gnt_valid` is 0.
- R2: A read to a block whose exclusive bit is clear is granted in the cycle after acceptance with `gnt_excl`=0 and no invalidation. The requester's presence bit is added to the existing holders.
- R3: A write to a block held by other caches drives `inv_req` to exactly those other holders from the cycle after acceptance, with `inv_blk` set to the block. Each bit falls in the cycle after that cache's acknowledgement is sampled.
- R4: A write that had to invalidate is granted (`gnt_valid`=1, `gnt_excl`=1, requester id and block echoed) exactly one cycle after the last outstanding acknowledgement is sampled. The block is then held by the requester alone, with the exclusive bit set.
- R5: A write to a block with no holders, or held only by the requester, is granted in the cycle after acceptance with `gnt_excl`=1 and no invalidation. The block then belongs to the requester alone and is exclusive.
- R6: A read to a block held exclusively by another cache first invalidates that owner and waits for its acknowledgement. It is granted with `gnt_excl`=0 one cycle after the acknowledgement. The block is then held by the requester alone, with the exclusive bit clear.
- R7: A read from the cache that already owns the block exclusively is granted in the cycle after acceptance with `gnt_excl`=1. The block's entry does not change.
- R8: While invalidations are outstanding, `req_ready` is 0 and no new request is accepted. `req_ready` returns to 1 in the grant cycle.
- R9: Acknowledgements from caches with no outstanding invalidation are ignored, whether the directory is idle or waiting. They neither complete nor delay a transaction.
- R10: `gnt_valid` is high for a single cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_cache | input | IDW | Requesting cache id |
| req_blk | input | BW | Block index |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| inv_req | output | NCACHE | Outstanding invalidation per cache |
| inv_blk | output | BW | Block the invalidations refer to |
| inv_ack | input | NCACHE | Acknowledgement pulse per cache |
| gnt_valid | output | 1 | Grant pulse |
| gnt_cache | output | IDW | Cache being granted |
| gnt_blk | output | BW | Block being granted |
| gnt_excl | output | 1 | Grantee now holds the only copy |

## Verification
The assertions assume that a requester keeps its request stable until it is accepted. They also assume that `req_cache` and `req_blk` stay within `NCACHE` and `NBLK`. The bench keeps a request unchanged until it sees `req_ready` and draws ids only from the legal ranges. It does not constrain acknowledgements at all: it sends well-timed, late, repeated and unsolicited pulses. This means the ignore rule of R9 is exercised under the same assumptions. Requests are concentrated on a few hot blocks, so that sharing, ownership recall and sole-holder upgrades all occur.

// File: rtl/bvd_pkg.sv
package bvd_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dir_state_t;
endpackage

// File: rtl/bvd_store.sv
module bvd_store #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 8,
  localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_blk,
  output logic [NCACHE-1:0] rd_pres,
  output logic              rd_excl,
  input  logic              wr_en,
  input  logic [BW-1:0]     wr_blk,
  input  logic [NCACHE-1:0] wr_pres,
  input  logic              wr_excl
);
  logic [NCACHE-1:0] pres_q [NBLK];
  logic              excl_q [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        pres_q[b] <= '0;
        excl_q[b] <= 1'b0;
      end
    end else if (wr_en) begin
      pres_q[wr_blk] <= wr_pres;
      excl_q[wr_blk] <= wr_excl;
    end
  end

  assign rd_pres = pres_q[rd_blk];
  assign rd_excl = excl_q[rd_blk];

  // R4: an exclusive entry always names exactly one holder
  p_excl_one_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_excl) |-> ($countones(wr_pres) == 1));
endmodule

// File: rtl/bvd_plan.sv
module bvd_plan #(
  parameter int NCACHE = 4
) (
  input  logic              is_write,
  input  logic [NCACHE-1:0] req_bit,
  input  logic [NCACHE-1:0] cur_pres,
  input  logic              cur_excl,
  output logic [NCACHE-1:0] targets,
  output logic              immediate,
  output logic [NCACHE-1:0] new_pres,
  output logic              new_excl,
  output logic              grant_excl
);
  logic [NCACHE-1:0] others;
  assign others = cur_pres & ~req_bit;

  always_comb begin
    targets    = '0;
    immediate  = 1'b1;
    new_pres   = cur_pres;
    new_excl   = cur_excl;
    grant_excl = 1'b0;
    if (is_write) begin
      targets    = others;
      immediate  = (others == '0);
      new_pres   = req_bit;
      new_excl   = 1'b1;
      grant_excl = 1'b1;
    end else if (cur_excl && (others != '0)) begin
      targets    = others;
      immediate  = 1'b0;
      new_pres   = req_bit;
      new_excl   = 1'b0;
    end else if (cur_excl) begin
      grant_excl = 1'b1;
    end else begin
      new_pres   = cur_pres | req_bit;
    end
  end
endmodule

// File: rtl/bvd_acks.sv
module bvd_acks #(
  parameter int NCACHE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCACHE-1:0] load_tgt,
  input  logic              active,
  input  logic [NCACHE-1:0] ack,
  output logic [NCACHE-1:0] pending,
  output logic              done
);
  logic [NCACHE-1:0] tgt_q, got_q, got_n;

  assign got_n   = got_q | (ack & tgt_q);
  assign pending = active ? (tgt_q & ~got_q) : '0;
  assign done    = active && (got_n == tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      got_q <= '0;
    end else if (load) begin
      tgt_q <= load_tgt;
      got_q <= '0;
    end else if (active) begin
      got_q <= got_n;
    end
  end

  // R3: outstanding invalidations only retire, never reappear mid-transaction
  p_inv_only_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(load)) |-> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/bitvec_dir.sv
module bitvec_dir #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 8,
  localparam int IDW   = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDW-1:0]    req_cache,
  input  logic [BW-1:0]     req_blk,
  input  logic              req_write,
  output logic [NCACHE-1:0] inv_req,
  output logic [BW-1:0]     inv_blk,
  input  logic [NCACHE-1:0] inv_ack,
  output logic              gnt_valid,
  output logic [IDW-1:0]    gnt_cache,
  output logic [BW-1:0]     gnt_blk,
  output logic              gnt_excl
);
  import bvd_pkg::*;

  dir_state_t        st_q;
  logic [IDW-1:0]    h_cache;
  logic [BW-1:0]     h_blk;
  logic              h_write;
  logic              accept, done;
  logic [NCACHE-1:0] req_bit, rd_pres, p_tgt, p_pres;
  logic              rd_excl, p_immed, p_excl, p_gexcl;
  logic              wr_en, wr_excl;
  logic [BW-1:0]     wr_blk;
  logic [NCACHE-1:0] wr_pres;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_bit   = NCACHE'(1) << req_cache;
  assign inv_blk   = h_blk;

  bvd_store #(.NCACHE(NCACHE), .NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_blk(req_blk), .rd_pres(rd_pres), .rd_excl(rd_excl),
    .wr_en(wr_en), .wr_blk(wr_blk), .wr_pres(wr_pres), .wr_excl(wr_excl));

  bvd_plan #(.NCACHE(NCACHE)) u_plan (
    .is_write(req_write), .req_bit(req_bit), .cur_pres(rd_pres), .cur_excl(rd_excl),
    .targets(p_tgt), .immediate(p_immed), .new_pres(p_pres), .new_excl(p_excl),
    .grant_excl(p_gexcl));

  bvd_acks #(.NCACHE(NCACHE)) u_acks (
    .clk(clk), .rst_n(rst_n), .load(accept && !p_immed), .load_tgt(p_tgt),
    .active(st_q == ST_WAIT), .ack(inv_ack), .pending(inv_req), .done(done));

  always_comb begin
    if (st_q == ST_WAIT) begin
      wr_en   = done;
      wr_blk  = h_blk;
      wr_pres = NCACHE'(1) << h_cache;
      wr_excl = h_write;
    end else begin
      wr_en   = accept && p_immed;
      wr_blk  = req_blk;
      wr_pres = p_pres;
      wr_excl = p_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      h_cache   <= '0;
      h_blk     <= '0;
      h_write   <= 1'b0;
      gnt_valid <= 1'b0;
      gnt_cache <= '0;
      gnt_blk   <= '0;
      gnt_excl  <= 1'b0;
    end else begin
      gnt_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          h_cache <= req_cache;
          h_blk   <= req_blk;
          h_write <= req_write;
          if (p_immed) begin
            gnt_valid <= 1'b1;
            gnt_cache <= req_cache;
            gnt_blk   <= req_blk;
            gnt_excl  <= p_gexcl;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (done) begin
          gnt_valid <= 1'b1;
          gnt_cache <= h_cache;
          gnt_blk   <= h_blk;
          gnt_excl  <= h_write;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled request channel always means invalidations are outstanding
  p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (inv_req != '0));
  // R5: a write with no other holder is granted on the next cycle
  p_sole_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && ((rd_pres & ~req_bit) == '0)) |=> (gnt_valid && gnt_excl));
  // R10: a grant without a fresh immediate acceptance is followed by a quiet cycle
  p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !accept) |=> !gnt_valid);
  // R1: nothing is invalidated while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (inv_req == '0));
endmodule

// File: tb/test_bitvec_dir.sv
module test_bitvec_dir;
  localparam int NC  = 4;
  localparam int NB  = 8;
  localparam int IDW = 2;
  localparam int BW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [IDW-1:0] req_cache = '0;
  logic [BW-1:0]  req_blk = '0;
  logic [NC-1:0]  inv_ack = '0;
  logic req_ready, gnt_valid, gnt_excl;
  logic [NC-1:0]  inv_req;
  logic [BW-1:0]  inv_blk, gnt_blk;
  logic [IDW-1:0] gnt_cache;

  always #5 clk = ~clk;

  bitvec_dir #(.NCACHE(NC), .NBLK(NB)) i_bitvec_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cache(req_cache), .req_blk(req_blk), .req_write(req_write),
    .inv_req(inv_req), .inv_blk(inv_blk), .inv_ack(inv_ack),
    .gnt_valid(gnt_valid), .gnt_cache(gnt_cache), .gnt_blk(gnt_blk), .gnt_excl(gnt_excl));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit [NC-1:0] mp [NB];
  bit          mx [NB];
  bit          m_wait = 0;
  bit [NC-1:0] m_tgt = 0, m_got = 0;
  int          m_c = 0, m_b = 0;
  bit          m_w = 0;
  bit          e_gv = 0, e_gx = 0, prev_gv = 0, spurious = 0;
  int          e_gc = 0, e_gb = 0;
  string       cls = "R2";

  task automatic model_step();
    bit [NC-1:0] rb, others;
    e_gv = 0;
    if (!m_wait) begin
      if (req_valid) begin
        rb = NC'(1) << req_cache;
        m_c = int'(req_cache); m_b = int'(req_blk); m_w = req_write;
        others = mp[m_b] & ~rb;
        spurious = (inv_ack != 0);
        if (m_w) begin
          if (others == 0) begin
            mp[m_b] = rb; mx[m_b] = 1;
            e_gv = 1; e_gx = 1; cls = "R5";
          end else begin
            m_wait = 1; m_tgt = others; m_got = 0; cls = "R4";
          end
        end else if (mx[m_b] && others != 0) begin
          m_wait = 1; m_tgt = others; m_got = 0; cls = "R6";
        end else if (mx[m_b]) begin
          e_gv = 1; e_gx = 1; cls = "R7";
        end else begin
          mp[m_b] = mp[m_b] | rb;
          e_gv = 1; e_gx = 0; cls = "R2";
        end
        e_gc = m_c; e_gb = m_b;
      end
    end else begin
      if ((inv_ack & ~(m_tgt & ~m_got)) != 0) spurious = 1;
      m_got = m_got | (inv_ack & m_tgt);
      if (m_got == m_tgt) begin
        m_wait = 0;
        mp[m_b] = NC'(1) << m_c; mx[m_b] = m_w;
        e_gv = 1; e_gx = m_w; e_gc = m_c; e_gb = m_b;
      end
    end
  endtask

  task automatic compare();
    bit [NC-1:0] e_inv;
    string gtag;
    e_inv = m_wait ? (m_tgt & ~m_got) : '0;
    chk(req_ready == !m_wait, "R8", "req_ready", int'(req_ready), int'(!m_wait));
    chk(inv_req == e_inv, m_w ? "R3" : "R6", "inv_req", int'(inv_req), int'(e_inv));
    if (e_inv != 0) chk(int'(inv_blk) == m_b, "R3", "inv_blk", int'(inv_blk), m_b);
    if (!e_gv && prev_gv) gtag = "R10";
    else if (spurious) gtag = "R9";
    else gtag = cls;
    chk(gnt_valid == e_gv, gtag, "gnt_valid", int'(gnt_valid), int'(e_gv));
    if (e_gv && gnt_valid) begin
      chk(int'(gnt_cache) == e_gc, cls, "gnt_cache", int'(gnt_cache), e_gc);
      chk(int'(gnt_blk) == e_gb, cls, "gnt_blk", int'(gnt_blk), e_gb);
      chk(gnt_excl == e_gx, cls, "gnt_excl", int'(gnt_excl), int'(e_gx));
    end
    prev_gv = e_gv;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mp[b] = 0; mx[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: idle state straight after reset
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(inv_req == '0, "R1", "inv_req", int'(inv_req), 0);
    chk(gnt_valid == 1'b0, "R1", "gnt_valid", int'(gnt_valid), 0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        compare();
      end
      // hold an unaccepted request, else draw a new one
      if (!(req_valid && m_wait)) begin
        req_valid = ($urandom % 3) != 0;
        req_cache = IDW'($urandom % NC);
        req_blk   = BW'((cyc < 3000) ? ($urandom % 3) : ($urandom % NB));
        req_write = ($urandom % 3) == 0;
      end
      for (int i = 0; i < NC; i++) begin
        if (m_wait && m_tgt[i] && !m_got[i]) inv_ack[i] = ($urandom % 3) == 0;
        else inv_ack[i] = ($urandom % 12) == 0;   // R9 unsolicited pulses
      end
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule